// File: doc/BRIEF.md
# CAN Bus Wake-Pattern Detector

This block sits behind a low-power bus receiver and watches the CAN bus while the device rests in sleep or standby. It accepts a bus phase only after the bus has held that level for a programmable number of low-rate ticks. It then steps through an ordered wake pattern: a held dominant, a held recessive, a second held dominant and a second held recessive. The whole pattern must finish inside a programmable window. If the window runs out, the detector parks until the bus is seen recessive and then starts over.

When the pattern completes and the supplies are good, the block raises a wake request on its receive-data output. The request shows either as a steady low or as a low/high square wave with a programmable half-period. Alongside it the block gives a one-cycle active-low interrupt pulse, if interrupts are enabled, and a one-cycle request to move from sleep to standby. The request is cleared by the operating-mode changes and by the core-supply conditions listed below. While no request is active, the receive-data output idles high.

Top module: `can_wake_detect`

## Requirements
- R1: The bus input (1 = dominant) passes through a two-stage synchroniser. A level counts as a filtered phase only after it has held for FILT_TICKS tick pulses. Shorter bursts produce no wake request.
- R2: Phases are accepted only in the order dominant, recessive, dominant, recessive. A dominant, a dominant, then a recessive does not complete the pattern.
- R3: Bus activity shorter than the filter time while the detector waits for a phase does not return it to the start, so short glitches between phases still allow detection.
- R4: If TIMEOUT_TICKS ticks pass after the first filtered dominant without the pattern completing, the detector abandons it and waits for a recessive bus before it re-arms. A later complete pattern is recognised again.
- R5: With cfg_toggle_i = 0, a recognised pattern drives rxd_o low, and rxd_o stays low until the request is cleared.
- R6: A request is raised only if vio_ok_i = 1 and either vcc_ok_i = 1 or cfg_vcc_ign_i = 1.
- R7: With cfg_toggle_i = 1, rxd_o starts low and changes level every TOGGLE_TICKS ticks while the request is active.
- R8: mode_i = normal clears the request. With cfg_vcc_ign_i = 0, vcc_ok_i = 0 clears it. With cfg_toggle_i = 1, mode_i = listen also clears it. A steady request survives listen mode.
- R9: On recognition, int_n_o pulses low for one clock if int_en_i = 1. stby_req_o pulses high for one clock only if mode_i was sleep.
- R10: mode_i encoding is sleep = 0, standby = 1, normal = 2, listen = 3. The detector runs in sleep and standby and is held at its start in normal and listen.
- R11: Synchronous reset leaves rxd_o = 1, int_n_o = 1 and stby_req_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_tick_i | input | 1 | One-cycle pulse of the low-rate timing tick |
| bus_dom_i | input | 1 | Asynchronous bus state from the receiver, 1 = dominant |
| mode_i | input | 2 | Operating mode: 0 sleep, 1 standby, 2 normal, 3 listen |
| vio_ok_i | input | 1 | I/O supply valid |
| vcc_ok_i | input | 1 | Core supply valid |
| cfg_toggle_i | input | 1 | 1 = toggling wake output, 0 = steady low |
| cfg_vcc_ign_i | input | 1 | 1 = ignore the core-supply check |
| int_en_i | input | 1 | Interrupt enable |
| rxd_o | output | 1 | Receive-data line carrying the wake request, idles high |
| int_n_o | output | 1 | Active-low interrupt pulse |
| stby_req_o | output | 1 | One-cycle request to move from sleep to standby |

## Verification
The bench builds the block with FILT_TICKS = 3, TIMEOUT_TICKS = 40 and TOGGLE_TICKS = 4, and drives a tick every second clock. With these values a filtered phase takes about a dozen clocks, and a pattern can time out in roughly eighty. The toggle output flips every eight clocks. So glitch rejection, in-window completion, expiry, re-arming and several toggle periods all fit into short scenarios. A reference model built from the same parameters is compared on every clock.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
  typedef enum logic [1:0] {
    MD_SLEEP  = 2'd0,
    MD_STBY   = 2'd1,
    MD_NORMAL = 2'd2,
    MD_LISTEN = 2'd3
  } op_mode_e;

  typedef enum logic [2:0] {
    SQ_D1    = 3'd0,
    SQ_R1    = 3'd1,
    SQ_D2    = 3'd2,
    SQ_R2    = 3'd3,
    SQ_REARM = 3'd4
  } seq_st_e;
endpackage

// File: rtl/wkd_filter.sv
module wkd_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TICKS  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_dom_i,
  input  logic tick_i,
  output logic bus_s_o,
  output logic ev_dom_o,
  output logic ev_rec_o
);
  localparam int CW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(FILT_TICKS - 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(FILT_TICKS);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CW-1:0]          run_q;
  logic                   same;

  // R1: synchroniser chain, length picked by parameter
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], bus_dom_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= bus_dom_i;
      end
    end
  endgenerate

  assign bus_s_o = sync_q[SYNC_STAGES-1];
  assign same    = (bus_s_o == prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      run_q    <= '0;
      ev_dom_o <= 1'b0;
      ev_rec_o <= 1'b0;
    end else begin
      prev_q <= bus_s_o;
      if (!same)                          run_q <= '0;
      else if (tick_i && run_q != RUN_MAX) run_q <= run_q + 1'b1;
      ev_dom_o <= same && tick_i && (run_q == RUN_LAST) &&  bus_s_o;
      ev_rec_o <= same && tick_i && (run_q == RUN_LAST) && !bus_s_o;
    end
  end
endmodule

// File: rtl/wkd_seq.sv
module wkd_seq
  import wkd_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    active_i,
  input  logic    tick_i,
  input  logic    bus_s_i,
  input  logic    ev_dom_i,
  input  logic    ev_rec_i,
  output logic    hit_o,
  output seq_st_e st_o
);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_TICKS - 1);

  seq_st_e       st_q;
  logic [TW-1:0] win_q;

  assign st_o = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_D1;
      win_q <= '0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (!active_i) begin
        st_q  <= SQ_D1;   // R10
        win_q <= '0;
      end else begin
        unique case (st_q)
          SQ_D1: if (ev_dom_i) begin
            st_q  <= SQ_R1;
            win_q <= '0;
          end
          SQ_R1, SQ_D2, SQ_R2: begin
            if (tick_i && win_q == TO_LAST) begin
              st_q <= SQ_REARM;          // R4 window expired
            end else begin
              if (tick_i) win_q <= win_q + 1'b1;
              // R3: only filtered events move the sequence
              if (st_q == SQ_R1 && ev_rec_i)      st_q <= SQ_D2;
              else if (st_q == SQ_D2 && ev_dom_i) st_q <= SQ_R2;
              else if (st_q == SQ_R2 && ev_rec_i) begin
                st_q  <= SQ_D1;
                hit_o <= 1'b1;
              end
            end
          end
          SQ_REARM: if (!bus_s_i) st_q <= SQ_D1;
          default: st_q <= SQ_D1;
        endcase
      end
    end
  end
endmodule

// File: rtl/wkd_out.sv
module wkd_out
  import wkd_pkg::*;
#(
  parameter int TOGGLE_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       hit_i,
  input  logic [1:0] mode_i,
  input  logic       vio_ok_i,
  input  logic       vcc_ok_i,
  input  logic       cfg_toggle_i,
  input  logic       cfg_vcc_ign_i,
  input  logic       int_en_i,
  output logic       rxd_o,
  output logic       int_n_o,
  output logic       stby_req_o
);
  localparam int GW = $clog2(TOGGLE_TICKS + 1);
  localparam logic [GW-1:0] TG_LAST = GW'(TOGGLE_TICKS - 1);

  logic          req_q, ph_q, sup_ok, clr, accept;
  logic [GW-1:0] tg_q;

  assign sup_ok = vio_ok_i && (vcc_ok_i || cfg_vcc_ign_i);          // R6
  assign clr    = (mode_i == MD_NORMAL) ||                          // R8
                  (!vcc_ok_i && !cfg_vcc_ign_i) ||
                  (cfg_toggle_i && mode_i == MD_LISTEN);
  assign accept = hit_i && sup_ok && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= 1'b0;
      ph_q       <= 1'b0;
      tg_q       <= '0;
      rxd_o      <= 1'b1;
      int_n_o    <= 1'b1;
      stby_req_o <= 1'b0;
    end else begin
      if (clr) begin
        req_q <= 1'b0;
      end else if (accept) begin
        req_q <= 1'b1;
        ph_q  <= 1'b0;
        tg_q  <= '0;
      end else if (req_q && tick_i) begin
        if (tg_q == TG_LAST) begin
          tg_q <= '0;
          ph_q <= ~ph_q;                                            // R7
        end else begin
          tg_q <= tg_q + 1'b1;
        end
      end
      rxd_o      <= ~req_q | (cfg_toggle_i & ph_q);                 // R5
      int_n_o    <= ~(accept & int_en_i);                           // R9
      stby_req_o <= accept && (mode_i == MD_SLEEP);
    end
  end
endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect
  import wkd_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int FILT_TICKS    = 5,
  parameter int TIMEOUT_TICKS = 1000,
  parameter int TOGGLE_TICKS  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lp_tick_i,
  input  logic       bus_dom_i,
  input  logic [1:0] mode_i,
  input  logic       vio_ok_i,
  input  logic       vcc_ok_i,
  input  logic       cfg_toggle_i,
  input  logic       cfg_vcc_ign_i,
  input  logic       int_en_i,
  output logic       rxd_o,
  output logic       int_n_o,
  output logic       stby_req_o
);
  logic    bus_s, ev_dom, ev_rec, hit, active;
  seq_st_e seq_st;

  assign active = (mode_i == MD_SLEEP) || (mode_i == MD_STBY);

  wkd_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TICKS(FILT_TICKS)) u_filt (
    .clk(clk), .rst(rst), .bus_dom_i(bus_dom_i), .tick_i(lp_tick_i),
    .bus_s_o(bus_s), .ev_dom_o(ev_dom), .ev_rec_o(ev_rec)
  );

  wkd_seq #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_seq (
    .clk(clk), .rst(rst), .active_i(active), .tick_i(lp_tick_i),
    .bus_s_i(bus_s), .ev_dom_i(ev_dom), .ev_rec_i(ev_rec),
    .hit_o(hit), .st_o(seq_st)
  );

  wkd_out #(.TOGGLE_TICKS(TOGGLE_TICKS)) u_out (
    .clk(clk), .rst(rst), .tick_i(lp_tick_i), .hit_i(hit), .mode_i(mode_i),
    .vio_ok_i(vio_ok_i), .vcc_ok_i(vcc_ok_i), .cfg_toggle_i(cfg_toggle_i),
    .cfg_vcc_ign_i(cfg_vcc_ign_i), .int_en_i(int_en_i),
    .rxd_o(rxd_o), .int_n_o(int_n_o), .stby_req_o(stby_req_o)
  );
endmodule

// File: rtl/wkd_checker.sv
module wkd_checker
  import wkd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       vio_ok_i,
  input logic       rxd_o,
  input logic       int_n_o,
  input logic       stby_req_o,
  input seq_st_e    st
);
  p_int_single_r9: assert property (@(posedge clk) disable iff (rst)
    !int_n_o |=> int_n_o);

  p_stby_from_sleep_r9: assert property (@(posedge clk) disable iff (rst)
    stby_req_o |-> $past(mode_i) == MD_SLEEP);

  p_need_vio_r6: assert property (@(posedge clk) disable iff (rst)
    !int_n_o |-> $past(vio_ok_i));

  p_normal_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MD_NORMAL) |=> ##1 rxd_o);

  p_order_r1_r2: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_R1) |-> ($past(st) == SQ_D1 || $past(st) == SQ_R1));

  p_order_d2_r2: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_D2) |-> ($past(st) == SQ_R1 || $past(st) == SQ_D2));

  p_rearm_exit_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == SQ_REARM && st != SQ_REARM) |-> st == SQ_D1);
endmodule

bind can_wake_detect wkd_checker u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .vio_ok_i(vio_ok_i),
  .rxd_o(rxd_o), .int_n_o(int_n_o), .stby_req_o(stby_req_o), .st(seq_st)
);

// File: tb/can_wake_detect_tb_top.sv
`timescale 1ns/1ps
module can_wake_detect_tb_top;
  localparam int FT = 3, TO = 40, TG = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bus = 1'b0;
  logic [1:0] mode = 2'd2;
  logic vio = 1'b1, vcc = 1'b1, ctog = 1'b0, cign = 1'b0, ien = 1'b1;
  logic rxd, intn, stby;

  always #4 clk = ~clk;   // 125 MHz

  can_wake_detect #(.SYNC_STAGES(2), .FILT_TICKS(FT), .TIMEOUT_TICKS(TO),
                    .TOGGLE_TICKS(TG)) dut_i (
    .clk(clk), .rst(rst), .lp_tick_i(tick), .bus_dom_i(bus), .mode_i(mode),
    .vio_ok_i(vio), .vcc_ok_i(vcc), .cfg_toggle_i(ctog), .cfg_vcc_ign_i(cign),
    .int_en_i(ien), .rxd_o(rxd), .int_n_o(intn), .stby_req_o(stby));

  always @(negedge clk) tick <= ~tick;

  // behavioural reference model
  int m_s1, m_s2, m_s3, m_run, m_st, m_win, m_tg;
  bit m_ed, m_er, m_hit, m_req, m_ph, m_rxd = 1, m_intn = 1, m_stby;
  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_run = 0; m_ed = 0; m_er = 0;
      m_st = 0; m_win = 0; m_hit = 0; m_req = 0; m_ph = 0; m_tg = 0;
      m_rxd = 1; m_intn = 1; m_stby = 0;
    end else begin
      bit same, n_ed, n_er, n_hit, sup, clr, acc, n_req, n_ph;
      int n_run, n_st, n_win, n_tg;
      same = (m_s2 == m_s3);
      n_ed = same && tick && m_run == FT - 1 && m_s2 == 1;
      n_er = same && tick && m_run == FT - 1 && m_s2 == 0;
      n_run = !same ? 0 : (tick && m_run != FT) ? m_run + 1 : m_run;
      n_st = m_st; n_win = m_win; n_hit = 0;
      if (mode > 1) begin n_st = 0; n_win = 0; end
      else if (m_st == 0) begin if (m_ed) begin n_st = 1; n_win = 0; end end
      else if (m_st <= 3) begin
        if (tick && m_win == TO - 1) n_st = 4;
        else begin
          if (tick) n_win = m_win + 1;
          if (m_st == 1 && m_er) n_st = 2;
          else if (m_st == 2 && m_ed) n_st = 3;
          else if (m_st == 3 && m_er) begin n_st = 0; n_hit = 1; end
        end
      end else if (m_s2 == 0) n_st = 0;
      sup = vio && (vcc || cign);
      clr = (mode == 2) || (!vcc && !cign) || (ctog && mode == 3);
      acc = m_hit && sup && !clr;
      n_req = m_req; n_ph = m_ph; n_tg = m_tg;
      if (clr) n_req = 0;
      else if (acc) begin n_req = 1; n_ph = 0; n_tg = 0; end
      else if (m_req && tick) begin
        if (m_tg == TG - 1) begin n_tg = 0; n_ph = !m_ph; end
        else n_tg = m_tg + 1;
      end
      m_rxd = !m_req || (ctog && m_ph);
      m_intn = !(acc && ien);
      m_stby = acc && mode == 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = bus;
      m_run = n_run; m_ed = n_ed; m_er = n_er;
      m_st = n_st; m_win = n_win; m_hit = n_hit;
      m_req = n_req; m_ph = n_ph; m_tg = n_tg;
    end
  end

  int mchk = 0, mfail = 0, n_int = 0, n_stb = 0, n_edge = 0;
  bit saw_low = 0, prev_rxd = 1;
  always @(negedge clk) begin
    if (!rst) begin
      mchk = mchk + 1;
      if (rxd !== m_rxd || intn !== m_intn || stby !== m_stby) begin
        mfail = mfail + 1;
        $display("FAIL R5 model compare: rxd/int_n/stby=%b%b%b expected %b%b%b",
                 rxd, intn, stby, m_rxd, m_intn, m_stby);
      end
      if (!intn) n_int = n_int + 1;
      if (stby) n_stb = n_stb + 1;
      if (rxd != prev_rxd) n_edge = n_edge + 1;
      if (!rxd) saw_low = 1;
      prev_rxd = rxd;
    end
  end

  int schk = 0, sfail = 0, b_int = 0, b_stb = 0;
  bit wd_fail = 0, done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    schk = schk + 1;
    if (act != exp) begin
      sfail = sfail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold(input bit lvl, input int n);
    bus = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input bit tg_m, input bit ig, input bit ie);
    mode = 2'd2; bus = 0; vio = 1; vcc = 1; ctog = tg_m; cign = ig; ien = ie;
    hold(0, 20);
    mode = 2'd0;
    hold(0, 4);
    b_int = n_int; b_stb = n_stb;
  endtask

  task automatic pat();
    hold(1, 12); hold(0, 12); hold(1, 12); hold(0, 12); hold(0, 6);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed",
               (mchk + schk + 1) - (mfail + sfail + int'(wd_fail)), mchk + schk + 1);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 rxd", rxd, 1); chk("R11 int_n", intn, 1); chk("R11 stby", stby, 0);

    // R1 short bursts only
    setup(0, 0, 1);
    for (int i = 0; i < 20; i++) begin hold(1, 3); hold(0, 3); end
    hold(0, 10);
    chk("R1 rxd after glitches", rxd, 1);
    chk("R1 no int", n_int - b_int, 0);

    // R5, R9, R8 steady request
    setup(0, 0, 1);
    pat();
    chk("R5 rxd low", rxd, 0);
    chk("R9 int pulse", n_int - b_int, 1);
    chk("R9 stby pulse", n_stb - b_stb, 1);
    hold(0, 60);
    chk("R5 rxd held low", rxd, 0);
    mode = 2'd3; hold(0, 10);
    chk("R8 steady survives listen", rxd, 0);
    mode = 2'd2; hold(0, 4);
    chk("R8 normal clears", rxd, 1);

    // R3 glitches between phases
    setup(0, 0, 1);
    hold(1, 12); hold(0, 4); hold(1, 3); hold(0, 12); hold(1, 3); hold(0, 3);
    hold(1, 12); hold(0, 12); hold(0, 6);
    chk("R3 detect through glitches", rxd, 0);

    // R2 wrong order
    setup(0, 0, 1);
    hold(1, 12); hold(0, 3); hold(1, 12); hold(0, 12); hold(0, 6);
    chk("R2 dom-dom-rec no request", rxd, 1);

    // R4 timeout then re-arm
    setup(0, 0, 1);
    hold(1, 12); hold(0, 100); hold(1, 12); hold(0, 12); hold(0, 6);
    chk("R4 expired pattern", rxd, 1);
    pat();
    chk("R4 re-armed detection", rxd, 0);
    setup(0, 0, 1);
    hold(1, 100); hold(0, 12); hold(1, 12); hold(0, 12); hold(0, 6);
    chk("R4 expiry while dominant", rxd, 1);

    // R6 supply gating
    setup(0, 0, 1); vio = 0; pat();
    chk("R6 no vio rxd", rxd, 1); chk("R6 no vio int", n_int - b_int, 0);
    setup(0, 0, 1); vcc = 0; pat();
    chk("R6 no vcc rxd", rxd, 1);
    setup(0, 1, 1); vcc = 0; pat();
    chk("R6 vcc ignored rxd", rxd, 0);

    // R10 standby detection, R8 core undervoltage
    setup(0, 0, 1); mode = 2'd1; pat();
    chk("R10 standby detect", rxd, 0);
    chk("R9 no stby pulse from standby", n_stb - b_stb, 0);
    vcc = 0; hold(0, 4);
    chk("R8 vcc undervoltage clears", rxd, 1);

    // R7 toggle
    setup(1, 0, 1); saw_low = 0; pat();
    chk("R7 started low", saw_low, 1);
    begin
      int e0 = n_edge;
      hold(0, 64);
      chk("R7 toggle edges", (n_edge - e0) >= 6 ? 1 : 0, 1);
    end
    mode = 2'd3; hold(0, 4);
    chk("R8 listen ends toggle", rxd, 1);

    // R10 held in normal and listen
    setup(0, 0, 1); mode = 2'd2; pat(); mode = 2'd3; pat();
    chk("R10 no request outside sleep/standby", rxd, 1);
    chk("R10 no int", n_int - b_int, 0);

    // R9 interrupt disabled
    setup(0, 0, 0); pat();
    chk("R9 request with int disabled", rxd, 0);
    chk("R9 int suppressed", n_int - b_int, 0);

    chk("R11 model run clean", mfail, 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL R11 watchdog expired: actual running expected finished");
    @(negedge clk);
    summary();
  end
endmodule